// File: doc/BRIEF.md
# Queue Pointer Pending-Work Notifier

This block keeps the head and tail pointers of four message queues that live in memory. Software or a hardware agent writes pointers through one write port and reads them back through a separate read port. Both ports address a pointer by queue index and by a head/tail select. Whenever the head and tail of a queue differ, that queue holds unconsumed entries, and the block drives a level interrupt for it. The interrupt stays high until the two pointers are written back to equal values.

The four queues are: processor messages (index 0), device messages (index 1), recoverable errors (index 2) and fatal errors (index 3). Queue 3 stores its pointers like the others but deliberately raises no interrupt. Its output bit is held low. The block does no memory access, no wrap arithmetic and no alignment checking. Pointers are stored and returned exactly as written.

Top module: `qptr_notify`

## Requirements
- R1: While `rst_n` is low, every head and tail pointer is cleared to zero and every bit of `irq_o` is low.
- R2: A write stores the full `PTR_W`-bit value of `wr_data`, and a later read of the same pointer returns it unmodified.
- R3: For queues 0, 1 and 2, `irq_o[q]` is high while head and tail of queue q differ and low while they are equal.
- R4: A write captured at a rising clock edge shows up on `rd_data` and on `irq_o` after that same edge. A read is combinational on `rd_q` and `rd_tail`.
- R5: Queue 3 never drives its interrupt, even while its head and tail differ. `irq_o[3]` stays 0.
- R6: A write to one queue leaves the pointers and interrupt bit of every other queue unchanged. When `wr_en` is low, nothing changes.
- R7: `wr_q` and `rd_q` select the queue by binary index 0 to 3. `wr_tail` and `rd_tail` select the tail pointer when 1 and the head pointer when 0.
- R8: Writing a head value equal to the tail (or a tail equal to the head) clears that queue's interrupt at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pointer write strobe |
| wr_q | input | 2 | Queue index of the write |
| wr_tail | input | 1 | 1 writes the tail, 0 writes the head |
| wr_data | input | 64 | Pointer value to store |
| rd_q | input | 2 | Queue index of the read |
| rd_tail | input | 1 | 1 reads the tail, 0 reads the head |
| rd_data | output | 64 | Stored pointer value |
| irq_o | output | 4 | Per-queue pending interrupt; bit 3 is always 0 |

## Verification
The bench builds the block with its defaults: 64-bit pointers, four queues, and queue 3 as the silent one. The 64-bit width lets all-ones and high-bit patterns prove that no bit is masked on the way in or out. With four queues, writes can be interleaved so that several interrupts are high at once and each is then cleared independently. Fixing the silent index at 3 puts the case of unequal pointers with no interrupt within reach of both the vector table and the directed tests.

// File: rtl/qptr_notify.sv
module qptr_notify #(
  parameter int PTR_W    = 64,
  parameter int NQ       = 4,
  parameter int SILENT_Q = 3,
  localparam int QW      = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [QW-1:0]    wr_q,
  input  logic             wr_tail,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [QW-1:0]    rd_q,
  input  logic             rd_tail,
  output logic [PTR_W-1:0] rd_data,
  output logic [NQ-1:0]    irq_o
);

  logic [PTR_W-1:0] head_q [NQ];
  logic [PTR_W-1:0] tail_q [NQ];

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic             hit;
    logic [PTR_W-1:0] head_nx, tail_nx;

    assign hit     = wr_en && (wr_q == QW'(i));
    assign head_nx = (hit && !wr_tail) ? wr_data : head_q[i];
    assign tail_nx = (hit &&  wr_tail) ? wr_data : tail_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        head_q[i] <= '0;
        tail_q[i] <= '0;
      end else begin
        head_q[i] <= head_nx;
        tail_q[i] <= tail_nx;
      end
    end

    if (i == SILENT_Q) begin : g_silent
      assign irq_o[i] = 1'b0;
    end else begin : g_live
      logic pend_q;
      always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (hit) pend_q <= (head_nx != tail_nx);
      end
      assign irq_o[i] = pend_q;
    end
  end

  assign rd_data = rd_tail ? tail_q[rd_q] : head_q[rd_q];

endmodule

// File: rtl/qptr_notify_chk.sv
module qptr_notify_chk #(
  parameter int PTR_W    = 64,
  parameter int NQ       = 4,
  parameter int SILENT_Q = 3,
  localparam int QW      = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [QW-1:0]    wr_q,
  input logic             wr_tail,
  input logic [PTR_W-1:0] wr_data,
  input logic [NQ-1:0]    irq_o,
  input logic [PTR_W-1:0] head_q [NQ],
  input logic [PTR_W-1:0] tail_q [NQ]
);

  p_head_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_tail) |=> head_q[$past(wr_q)] == $past(wr_data));

  p_tail_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_tail) |=> tail_q[$past(wr_q)] == $past(wr_data));

  for (genvar i = 0; i < NQ; i++) begin : g_chk
    p_others_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_q == QW'(i)) |=>
        ($stable(head_q[i]) && $stable(tail_q[i]) && $stable(irq_o[i])));

    if (i != SILENT_Q) begin : g_live
      p_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[i] == (head_q[i] != tail_q[i]));
    end
  end

endmodule

bind qptr_notify qptr_notify_chk #(.PTR_W(PTR_W), .NQ(NQ), .SILENT_Q(SILENT_Q)) u_chk (.*);

// File: tb/sim_qptr_notify.sv
module sim_qptr_notify;
  localparam int CLK_P = 10;
  localparam int NV    = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_q = '0;
  logic        wr_tail = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_q = '0;
  logic        rd_tail = 1'b0;
  logic [63:0] rd_data;
  logic [3:0]  irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  qptr_notify u0 (.*);

  // entry: {queue[70:69], tail[68], data[67:4], expected irq[3:0]}
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 1'b0, 64'h5,                     4'b0001},
    {2'd0, 1'b1, 64'h5,                     4'b0000},
    {2'd1, 1'b1, 64'h9,                     4'b0010},
    {2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF,   4'b0110},
    {2'd3, 1'b1, 64'h7,                     4'b0110},
    {2'd1, 1'b0, 64'h9,                     4'b0100},
    {2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF,   4'b0000},
    {2'd0, 1'b1, 64'hA5A5_0000_0000_0001,   4'b0001},
    {2'd3, 1'b0, 64'h7,                     4'b0001},
    {2'd0, 1'b0, 64'hA5A5_0000_0000_0001,   4'b0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] q, input logic t, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_q = q; wr_tail = t; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] q, input logic t, input logic [63:0] exp);
    rd_q = q; rd_tail = t;
    #1 chk(req, rd_data, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 irq", {60'd0, irq_o}, 64'd0);
    for (int q = 0; q < 4; q++) begin
      rd_chk("R1 head", q[1:0], 1'b0, 64'd0);
      rd_chk("R1 tail", q[1:0], 1'b1, 64'd0);
    end
    @(negedge clk) rst_n = 1'b1;

    // R2 R3 R4 R5 R7 R8: vector walk, checked right after the capturing edge
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][70:69], VEC[v][68], VEC[v][67:4]);
      chk("R3/R4/R5/R8 irq", {60'd0, irq_o}, {60'd0, VEC[v][3:0]});
      rd_chk("R2/R7 readback", VEC[v][70:69], VEC[v][68], VEC[v][67:4]);
    end

    // R6: other queues kept their pointers through the walk
    rd_chk("R6 q2 head kept", 2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R6 q1 tail kept", 2'd1, 1'b1, 64'h9);

    // R5: silent queue with unequal pointers
    wr(2'd3, 1'b0, 64'h100);
    chk("R5 silent queue", {63'd0, irq_o[3]}, 64'd0);
    rd_chk("R5 silent stores", 2'd3, 1'b0, 64'h100);

    // R6: raise q1, then write q2 and idle; q1 unchanged
    wr(2'd1, 1'b1, 64'h20);
    wr(2'd2, 1'b0, 64'h3);
    chk("R6 isolation", {60'd0, irq_o}, 64'b0110);
    repeat (3) @(posedge clk);
    #1 chk("R6 idle hold", {60'd0, irq_o}, 64'b0110);

    // R8: rewriting same value keeps irq, matching tail clears it
    wr(2'd1, 1'b1, 64'h20);
    chk("R8 same value", {63'd0, irq_o[1]}, 64'd1);
    wr(2'd1, 1'b0, 64'h20);
    chk("R8 equal clears", {63'd0, irq_o[1]}, 64'd0);

    // R4: readback combinational on read select
    rd_chk("R4 combinational read", 2'd2, 1'b0, 64'h3);

    // R1: reset mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1 chk("R1 mid-run irq", {60'd0, irq_o}, 64'd0);
    rd_chk("R1 mid-run head", 2'd2, 1'b0, 64'd0);
    rd_chk("R1 mid-run tail", 2'd1, 1'b1, 64'd0);

    finish_run();
  end
endmodule